// File: doc/BRIEF.md
# OTP Word Programming Sequencer

This block sequences the programming of a one-time-programmable word memory organised as 2^ADDR_W words of DATA_W bits (256K x 16 by default). It raises the device supplies in a safe order and programs every address in ascending order. Each word gets a single unchecked program pulse, then a verify loop that adds one pulse per failed verify until the word matches or the pulse budget runs out. After the last word it drops both supplies to their normal level and reads every word back against the intended data.

The intended data comes from a host port. The sequencer raises a request carrying an address, and the host answers with a one-cycle response strobe and the word, after any number of cycles. Every time requirement is given in nanoseconds and turned into clock cycles through the CLK_MHZ parameter, rounding up, with a minimum of one cycle. Supply generation itself is outside the block. Only the two level-select outputs and the control timing are produced.

Top module: `otp_prog_sequencer`

## Requirements
- R1: While rst is high and after it falls, mem_ce_n and mem_oe_n are 1, vcc_prog and vpp_prog are 0, and busy, done and dreq_valid are 0.
- R2: A run starts by setting vcc_prog alone for SUPPLY_NS before vpp_prog rises. vpp_prog is never 1 while vcc_prog is 0. When lowering, vpp_prog falls at least SUPPLY_NS before vcc_prog falls.
- R3: Every program pulse holds mem_ce_n at 0 for exactly PULSE_NS, which is 50 cycles at 1 MHz, while vpp_prog is 1.
- R4: Before each program pulse, mem_addr, mem_dout and the driven data bus (mem_dout_en=1) stay stable with mem_oe_n=1 for at least SETUP_NS. After the pulse the data stays driven and unchanged for at least HOLD_NS.
- R5: The first program pulse at an address comes before any verify read of that address, so every processed address gets at least one pulse.
- R6: A word that needs n pulses to take, with n ≤ RETRY_LIMIT+1 (11), receives exactly n pulses. Each pulse is followed by a verify read.
- R7: If a word still fails verify after RETRY_LIMIT+1 pulses, no further pulses occur. The supplies are lowered, no read-back takes place, and the run ends with done=1, pass=0 and fail_addr set to that address.
- R8: A verify read drives mem_oe_n=0 with mem_ce_n=1 and mem_dout_en=0 for VERIFY_NS before the word is sampled. The bus is then left undriven for FLOAT_NS.
- R9: Addresses are programmed in ascending order starting at 0. The address of each pulse equals the address of the previous pulse or is one above it.
- R10: After programming succeeds, each word is read once with mem_ce_n=0, mem_oe_n=0 and both supply selects at 0. If all words match, pass=1 and fail_addr=0. Otherwise pass=0 and fail_addr holds the lowest mismatching address.
- R11: done is 1 only after a run completes, with busy=0, and it stays until the next start. start is ignored while busy=1.
- R12: dreq_valid stays high with a stable dreq_addr until drsp_valid. Exactly one response is consumed per address in each phase: 2^ADDR_W x 2 on a pass, or k+1 when address k fails programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (only when not busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, status valid |
| pass | output | 1 | Overall result, valid with done |
| fail_addr | output | ADDR_W | First failing address, 0 on pass |
| dreq_valid | output | 1 | Intended-data request to host |
| dreq_addr | output | ADDR_W | Address of requested word |
| drsp_valid | input | 1 | Host response strobe |
| drsp_data | input | DATA_W | Intended word from host |
| mem_addr | output | ADDR_W | Device address |
| mem_dout | output | DATA_W | Data driven to device |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DATA_W | Data read from device |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| vcc_prog | output | 1 | Supply at programming level when 1 |
| vpp_prog | output | 1 | Programming voltage applied when 1 |

## Verification
Two events can land in the same cycle. One is the host response arriving in the cycle right after the request appears. The other is the final verify of the last address coinciding with the supply-lowering step, including the case where that verify fails on the pulse budget. The bench varies the response latency from zero to two cycles and places a word that needs exactly eleven pulses or twelve pulses at the middle and last addresses. It also asserts start while a run is busy. Each case is judged from ports only: pulse counts per address, the supply ordering gaps, the response and read-back counts, and the final pass and fail_addr.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_VCC_UP,
        S_VPP_UP,
        S_FETCH,
        S_SETUP,
        S_PULSE,
        S_HOLD,
        S_VFY,
        S_FLOAT,
        S_VPP_DN,
        S_VCC_DN,
        S_RFETCH,
        S_RREAD,
        S_RFLOAT,
        S_DONE
    } seq_state_e;

    // Round a duration in ns up to whole clock cycles, never below one.
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned mhz);
        int unsigned c;
        c = (ns * mhz + 999) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/otp_addr_walker.sv
module otp_addr_walker #(
    parameter int AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [AW-1:0] addr,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = &addr;
endmodule

// File: rtl/otp_pulse_tally.sv
module otp_pulse_tally #(
    parameter int LIMIT = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc && (cnt != CW'(LIMIT)))
            cnt <= cnt + 1'b1;
    end

    assign at_limit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/otp_prog_sequencer.sv
module otp_prog_sequencer
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W      = 18,
    parameter int DATA_W      = 16,
    parameter int CLK_MHZ     = 100,
    parameter int PULSE_NS    = 50000,
    parameter int SETUP_NS    = 2000,
    parameter int HOLD_NS     = 2000,
    parameter int SUPPLY_NS   = 2000,
    parameter int VERIFY_NS   = 150,
    parameter int FLOAT_NS    = 130,
    parameter int READ_NS     = 150,
    parameter int RETRY_LIMIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] fail_addr,
    output logic              dreq_valid,
    output logic [ADDR_W-1:0] dreq_addr,
    input  logic              drsp_valid,
    input  logic [DATA_W-1:0] drsp_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_dout_en,
    input  logic [DATA_W-1:0] mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              vcc_prog,
    output logic              vpp_prog
);
    localparam int unsigned PW_CYC = ns2cyc(PULSE_NS,  CLK_MHZ);
    localparam int unsigned SU_CYC = ns2cyc(SETUP_NS,  CLK_MHZ);
    localparam int unsigned DH_CYC = ns2cyc(HOLD_NS,   CLK_MHZ);
    localparam int unsigned VS_CYC = ns2cyc(SUPPLY_NS, CLK_MHZ);
    localparam int unsigned OE_CYC = ns2cyc(VERIFY_NS, CLK_MHZ);
    localparam int unsigned DF_CYC = ns2cyc(FLOAT_NS,  CLK_MHZ);
    localparam int unsigned RD_CYC = ns2cyc(READ_NS,   CLK_MHZ);
    localparam int TMR_W = $clog2(PW_CYC + SU_CYC + DH_CYC + VS_CYC
                                  + OE_CYC + DF_CYC + RD_CYC + 1);
    localparam int PULSE_LIMIT = RETRY_LIMIT + 1;

    localparam logic [TMR_W-1:0] LD_PW = TMR_W'(PW_CYC - 1);
    localparam logic [TMR_W-1:0] LD_SU = TMR_W'(SU_CYC - 1);
    localparam logic [TMR_W-1:0] LD_DH = TMR_W'(DH_CYC - 1);
    localparam logic [TMR_W-1:0] LD_VS = TMR_W'(VS_CYC - 1);
    localparam logic [TMR_W-1:0] LD_OE = TMR_W'(OE_CYC - 1);
    localparam logic [TMR_W-1:0] LD_DF = TMR_W'(DF_CYC - 1);
    localparam logic [TMR_W-1:0] LD_RD = TMR_W'(RD_CYC - 1);

    seq_state_e st, st_d;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;

    logic              a_clr, a_inc, a_last;
    logic [ADDR_W-1:0] addr;

    logic p_clr, p_inc, p_limit;

    logic [DATA_W-1:0] word_q;
    logic              word_ld;
    logic              cmp_en;
    logic              match_q;
    logic              failed_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic              record_fail;
    logic              run_start;

    otp_phase_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    otp_addr_walker #(.AW(ADDR_W)) u_walker (
        .clk  (clk),
        .rst  (rst),
        .clr  (a_clr),
        .inc  (a_inc),
        .addr (addr),
        .last (a_last)
    );

    otp_pulse_tally #(.LIMIT(PULSE_LIMIT)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clr      (p_clr),
        .inc      (p_inc),
        .at_limit (p_limit)
    );

    assign run_start = start && ((st == S_IDLE) || (st == S_DONE));

    always_comb begin
        st_d     = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        a_clr    = 1'b0;
        a_inc    = 1'b0;
        p_clr    = 1'b0;
        p_inc    = 1'b0;
        word_ld  = 1'b0;
        cmp_en   = 1'b0;
        unique case (st)
            S_IDLE, S_DONE: begin
                if (start) begin
                    st_d = S_VCC_UP; tmr_load = 1'b1; tmr_val = LD_VS;
                    a_clr = 1'b1; p_clr = 1'b1;
                end
            end
            S_VCC_UP: if (tmr_zero) begin
                st_d = S_VPP_UP; tmr_load = 1'b1; tmr_val = LD_VS;
            end
            S_VPP_UP: if (tmr_zero) st_d = S_FETCH;
            S_FETCH: if (drsp_valid) begin
                word_ld = 1'b1;
                st_d = S_SETUP; tmr_load = 1'b1; tmr_val = LD_SU;
            end
            S_SETUP: if (tmr_zero) begin
                st_d = S_PULSE; tmr_load = 1'b1; tmr_val = LD_PW;
            end
            S_PULSE: if (tmr_zero) begin
                p_inc = 1'b1;
                st_d = S_HOLD; tmr_load = 1'b1; tmr_val = LD_DH;
            end
            S_HOLD: if (tmr_zero) begin
                st_d = S_VFY; tmr_load = 1'b1; tmr_val = LD_OE;
            end
            S_VFY: if (tmr_zero) begin
                cmp_en = 1'b1;
                st_d = S_FLOAT; tmr_load = 1'b1; tmr_val = LD_DF;
            end
            S_FLOAT: if (tmr_zero) begin
                if (match_q) begin
                    if (a_last) begin
                        st_d = S_VPP_DN; tmr_load = 1'b1; tmr_val = LD_VS;
                    end else begin
                        a_inc = 1'b1; p_clr = 1'b1; st_d = S_FETCH;
                    end
                end else if (p_limit) begin
                    st_d = S_VPP_DN; tmr_load = 1'b1; tmr_val = LD_VS;
                end else begin
                    st_d = S_SETUP; tmr_load = 1'b1; tmr_val = LD_SU;
                end
            end
            S_VPP_DN: if (tmr_zero) begin
                st_d = S_VCC_DN; tmr_load = 1'b1; tmr_val = LD_VS;
            end
            S_VCC_DN: if (tmr_zero) begin
                if (failed_q) begin
                    st_d = S_DONE;
                end else begin
                    a_clr = 1'b1; st_d = S_RFETCH;
                end
            end
            S_RFETCH: if (drsp_valid) begin
                word_ld = 1'b1;
                st_d = S_RREAD; tmr_load = 1'b1; tmr_val = LD_RD;
            end
            S_RREAD: if (tmr_zero) begin
                cmp_en = 1'b1;
                st_d = S_RFLOAT; tmr_load = 1'b1; tmr_val = LD_DF;
            end
            S_RFLOAT: if (tmr_zero) begin
                if (a_last) begin
                    st_d = S_DONE;
                end else begin
                    a_inc = 1'b1; st_d = S_RFETCH;
                end
            end
            default: st_d = S_IDLE;
        endcase
    end

    // A programming failure ends the run; a read-back mismatch keeps only the first address.
    assign record_fail = tmr_zero && !match_q &&
                         (((st == S_FLOAT) && p_limit) || (st == S_RFLOAT));

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            word_q      <= '0;
            match_q     <= 1'b0;
            failed_q    <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            st <= st_d;
            if (word_ld)
                word_q <= drsp_data;
            if (cmp_en)
                match_q <= (mem_din == word_q);
            if (run_start) begin
                failed_q    <= 1'b0;
                fail_addr_q <= '0;
            end else if (record_fail && !failed_q) begin
                failed_q    <= 1'b1;
                fail_addr_q <= addr;
            end
        end
    end

    assign busy        = (st != S_IDLE) && (st != S_DONE);
    assign done        = (st == S_DONE);
    assign pass        = done && !failed_q;
    assign fail_addr   = fail_addr_q;
    assign dreq_valid  = (st == S_FETCH) || (st == S_RFETCH);
    assign dreq_addr   = addr;
    assign mem_addr    = addr;
    assign mem_dout    = word_q;
    assign mem_dout_en = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
    assign mem_ce_n    = !((st == S_PULSE) || (st == S_RREAD));
    assign mem_oe_n    = !((st == S_VFY) || (st == S_RREAD));
    assign vcc_prog    = (st >= S_VCC_UP) && (st <= S_VPP_DN);
    assign vpp_prog    = (st >= S_VPP_UP) && (st <= S_FLOAT);

endmodule

// File: rtl/otp_prog_checker.sv
module otp_prog_checker
    import otp_seq_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_MHZ  = 100,
    parameter int PULSE_NS = 50000,
    parameter int SETUP_NS = 2000
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              dreq_valid,
    input logic [ADDR_W-1:0] dreq_addr,
    input logic              drsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dout,
    input logic              mem_dout_en,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              vcc_prog,
    input logic              vpp_prog
);
    localparam int unsigned PW_CYC = ns2cyc(PULSE_NS, CLK_MHZ);
    localparam int unsigned SU_CYC = ns2cyc(SETUP_NS, CLK_MHZ);

    int unsigned       lo_cnt;
    int unsigned       su_cnt;
    logic [ADDR_W-1:0] prev_addr;
    logic [DATA_W-1:0] prev_dout;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= 0;
            su_cnt    <= 0;
            prev_addr <= '0;
            prev_dout <= '0;
        end else begin
            lo_cnt <= mem_ce_n ? 0 : lo_cnt + 1;
            if (mem_ce_n && mem_oe_n && mem_dout_en)
                su_cnt <= (su_cnt != 0 && mem_addr == prev_addr && mem_dout == prev_dout)
                          ? su_cnt + 1 : 1;
            else
                su_cnt <= 0;
            prev_addr <= mem_addr;
            prev_dout <= mem_dout;
        end
    end

    assert_vpp_needs_vcc_R2: assert property (@(posedge clk) disable iff (rst)
        vpp_prog |-> vcc_prog);

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        (vpp_prog && $rose(mem_ce_n)) |-> (lo_cnt == PW_CYC));

    assert_setup_before_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (vpp_prog && $fell(mem_ce_n)) |-> (su_cnt >= SU_CYC));

    assert_verify_bus_free_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !mem_dout_en);

    assert_verify_ce_high_R8: assert property (@(posedge clk) disable iff (rst)
        (vpp_prog && !mem_oe_n) |-> mem_ce_n);

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && mem_ce_n && !vcc_prog && !vpp_prog));

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (dreq_valid && !drsp_valid) |=> (dreq_valid && $stable(dreq_addr)));

endmodule

bind otp_prog_sequencer otp_prog_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CLK_MHZ  (CLK_MHZ),
    .PULSE_NS (PULSE_NS),
    .SETUP_NS (SETUP_NS)
) u_checker (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .dreq_valid  (dreq_valid),
    .dreq_addr   (dreq_addr),
    .drsp_valid  (drsp_valid),
    .mem_addr    (mem_addr),
    .mem_dout    (mem_dout),
    .mem_dout_en (mem_dout_en),
    .mem_ce_n    (mem_ce_n),
    .mem_oe_n    (mem_oe_n),
    .vcc_prog    (vcc_prog),
    .vpp_prog    (vpp_prog)
);

// File: tb/tb_otp_prog_sequencer.sv
module tb_otp_prog_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 3;
    localparam int DW  = 16;
    localparam int W   = 1 << AW;
    localparam int PW  = 50;   // 50 us at 1 MHz
    localparam int SU  = 2;
    localparam int DH  = 2;
    localparam int VS  = 2;
    localparam int RL  = 10;
    localparam int MAXP = RL + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          busy, done, pass;
    logic [AW-1:0] fail_addr;
    logic          dreq_valid;
    logic [AW-1:0] dreq_addr;
    logic          drsp_valid;
    logic [DW-1:0] drsp_data;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dout;
    logic          mem_dout_en;
    logic [DW-1:0] mem_din;
    logic          mem_ce_n, mem_oe_n, vcc_prog, vpp_prog;

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_prog_sequencer #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(1), .RETRY_LIMIT(RL)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail_addr(fail_addr), .dreq_valid(dreq_valid),
        .dreq_addr(dreq_addr), .drsp_valid(drsp_valid), .drsp_data(drsp_data),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .mem_din(mem_din), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .vcc_prog(vcc_prog), .vpp_prog(vpp_prog)
    );

    // Device and host model state
    logic [DW-1:0] intended [W];
    logic [DW-1:0] stored   [W];
    int  need   [W];
    bit  corrupt[W];
    int  pcount [W];
    int  rd_count, rsp_count, lat;
    int  v_r2, v_r3, v_r4, v_r5, v_r8, v_r9;
    int  tests = 0, fails = 0, cyc = 0;
    bit  timeout = 0;

    assign mem_din = (!mem_oe_n) ? stored[mem_addr] : '0;

    // Monitor state
    int  lowc = 0, suc = 0, hdc = 0, gapc = 0;
    bit  in_hold = 0, pvpp = 0, pvcc = 0, pce = 1, prd = 0;
    logic [AW-1:0] pa = '0, last_pa = '0;
    logic [DW-1:0] pd = '0;

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) timeout = 1;
        if (!rst) begin
            // R2 supply ordering
            if (vpp_prog && !vcc_prog) v_r2++;
            if (vpp_prog && !pvpp && gapc < VS) v_r2++;
            if (!vcc_prog && pvcc && gapc < VS) v_r2++;
            gapc = (vcc_prog && !vpp_prog) ? gapc + 1 : 0;
            // R4 hold after pulse
            if (in_hold) begin
                if (!mem_dout_en) begin
                    if (hdc < DH) v_r4++;
                    in_hold = 0;
                end else if (mem_dout == pd && mem_addr == pa) hdc++;
                else begin v_r4++; in_hold = 0; end
            end
            // R4 setup before pulse
            if (!mem_ce_n && pce && vpp_prog && suc < SU) v_r4++;
            // Pulse end: program model, R3 width, R9 order
            if (!mem_ce_n) lowc++;
            else begin
                if (lowc > 0 && vpp_prog) begin
                    if (lowc != PW) v_r3++;
                    if (mem_addr != last_pa && mem_addr != last_pa + 1'b1) v_r9++;
                    last_pa = mem_addr;
                    pcount[mem_addr]++;
                    if (pcount[mem_addr] >= need[mem_addr])
                        stored[mem_addr] = stored[mem_addr] & mem_dout;
                    in_hold = 1; hdc = 1;
                end
                lowc = 0;
            end
            if (mem_ce_n && mem_oe_n && mem_dout_en)
                suc = (suc > 0 && mem_addr == pa && mem_dout == pd) ? suc + 1 : 1;
            else suc = 0;
            // R5 and R8 verify reads
            if (!mem_oe_n && vpp_prog) begin
                if (pcount[mem_addr] == 0) v_r5++;
                if (!mem_ce_n || mem_dout_en) v_r8++;
            end
            // R10 read-back cycles at normal supply
            if (!mem_ce_n && !mem_oe_n && !vpp_prog && !vcc_prog && !prd) rd_count++;
            prd = !mem_ce_n && !mem_oe_n;
            // Post-programming disturbance injected when the programming voltage drops
            if (!vpp_prog && pvpp)
                for (int a = 0; a < W; a++)
                    if (corrupt[a]) stored[a] = stored[a] ^ 16'h0002;
        end
        pvpp = vpp_prog; pvcc = vcc_prog; pce = mem_ce_n;
        pa = mem_addr; pd = mem_dout;
    end

    // Host responder with latency 0..2
    initial begin
        drsp_valid = 1'b0;
        drsp_data  = '0;
        lat = 0;
        forever begin
            @(negedge clk);
            drsp_valid = 1'b0;
            if (!rst && dreq_valid) begin
                if (lat == 0) begin
                    drsp_valid = 1'b1;
                    drsp_data  = intended[dreq_addr];
                    rsp_count++;
                    lat = int'($urandom % 3);
                end else lat--;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_prog_fail();
        for (int a = 0; a < W; a++) if (need[a] > MAXP) return a;
        return -1;
    endfunction

    function automatic int exp_read_fail();
        for (int a = 0; a < W; a++) if (corrupt[a]) return a;
        return -1;
    endfunction

    function automatic int exp_pulses(input int a, input int pf);
        if (pf >= 0 && a > pf) return 0;
        if (need[a] > MAXP) return MAXP;
        return (need[a] < 1) ? 1 : need[a];
    endfunction

    task automatic run_case(input string name, input bit poke);
        int pf, rf, ef;
        bit ep;
        for (int a = 0; a < W; a++) begin
            stored[a]   = 16'hFFFF;
            pcount[a]   = 0;
            intended[a] = 16'($urandom) & 16'hFFFE;
        end
        rd_count = 0; rsp_count = 0; last_pa = '0;
        v_r2 = 0; v_r3 = 0; v_r4 = 0; v_r5 = 0; v_r8 = 0; v_r9 = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;           // R11: must be ignored while busy
            @(negedge clk); start = 1'b0;
            chk(busy == 1'b1, "R11 busy after start while busy", busy, 1);
        end
        while (!done && !timeout) @(negedge clk);
        pf = exp_prog_fail();
        rf = exp_read_fail();
        ef = (pf >= 0) ? pf : rf;
        ep = (ef < 0);
        $display("[TB] case %s", name);
        chk(done == 1'b1 && busy == 1'b0, "R11 done without busy", done, 1);
        chk(pass == ep, (pf >= 0) ? "R7 pass flag" : "R10 pass flag", pass, ep);
        chk(int'(fail_addr) == (ep ? 0 : ef), (pf >= 0) ? "R7 fail_addr" : "R10 fail_addr",
            fail_addr, ep ? 0 : ef);
        for (int a = 0; a < W; a++)
            chk(pcount[a] == exp_pulses(a, pf), "R6 pulses per address", pcount[a],
                exp_pulses(a, pf));
        chk(rsp_count == ((pf >= 0) ? pf + 1 : 2 * W), "R12 responses", rsp_count,
            (pf >= 0) ? pf + 1 : 2 * W);
        chk(rd_count == ((pf >= 0) ? 0 : W), "R10 read-back count", rd_count,
            (pf >= 0) ? 0 : W);
        chk(v_r2 == 0 && !vcc_prog && !vpp_prog, "R2 supply order", v_r2, 0);
        chk(v_r3 == 0, "R3 pulse width", v_r3, 0);
        chk(v_r4 == 0, "R4 setup/hold", v_r4, 0);
        chk(v_r5 == 0, "R5 blind pulse first", v_r5, 0);
        chk(v_r8 == 0, "R8 verify bus", v_r8, 0);
        chk(v_r9 == 0, "R9 address order", v_r9, 0);
        repeat (5) @(negedge clk);
        chk(done == 1'b1, "R11 done held", done, 1);
    endtask

    task automatic set_needs(input int lo, input int span);
        for (int a = 0; a < W; a++) begin
            need[a] = lo + int'($urandom % span);
            corrupt[a] = 1'b0;
        end
    endtask

    initial begin
        void'($urandom(32'd7151));
        rst = 1'b1; start = 1'b0;
        set_needs(1, 1);
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !vcc_prog && !vpp_prog && !busy && !done && !dreq_valid,
            "R1 reset state", {mem_ce_n, mem_oe_n, vcc_prog, vpp_prog, busy, done}, 6'b110000);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && !vcc_prog && !vpp_prog && !busy && !done,
            "R1 idle after reset", {mem_ce_n, mem_oe_n, busy, done}, 4'b1100);

        set_needs(1, 1);               run_case("single pulse each", 0);
        set_needs(1, 4);               run_case("random needs", 0);
        set_needs(1, 1); need[5] = 11; run_case("eleven pulses boundary", 0);
        set_needs(1, 3); need[3] = 12; run_case("budget exhausted mid", 0);
        set_needs(1, 1); need[7] = 12; run_case("budget exhausted last", 0);
        set_needs(1, 2); need[7] = 11; corrupt[6] = 1'b1; run_case("read-back mismatch", 0);
        set_needs(1, 3); corrupt[2] = 1'b1; corrupt[6] = 1'b1; run_case("two mismatches", 0);
        set_needs(2, 1);               run_case("start while busy", 1);
        for (int k = 0; k < 3; k++) begin
            set_needs(1, 13);
            corrupt[$urandom % W] = ($urandom % 2) == 1;
            run_case("random mix", 0);
        end

        chk(!timeout, "watchdog", cyc, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule